// File: doc/BRIEF.md
# Three-Phase Gate-Drive Interlock Controller

This block sits between a motor-control core and the gate drivers of a three-phase inverter. For each phase it receives a high-side and a low-side on-command and produces the two gate-enable signals for that phase. Three rules guard the commands on the way. A phase whose two commands are active together has both gates held off. Every turn-on edge waits a fixed dead time, counted in clock cycles from the moment the opposite gate of the phase is off. Supply-good flags gate the outputs: one flag for the shared low-side supply turns all six gates off, and one flag per phase for the bootstrap supply turns off only that phase's high-side gate.

All ten inputs pass through a two-flop synchronizer, so a turn-off takes a fixed two-edge latency and a turn-on takes the same latency plus the dead time. The dead time is given in nanoseconds together with the clock period and is converted to cycles when the design is built. With the defaults (270 ns, 5 ns clock) it is 54 cycles. After reset, and after any supply fault clears, a gate turns on only once its command has been seen low and then high again.

Top module: `inverter_gate_guard`

## Requirements
- R1: Each phase p (0..2) drives gate_hi[p] and gate_lo[p] from cmd_hi[p], cmd_lo[p], vdd_ok and boot_ok[p] only. Commands of the other phases have no effect on it.
- R2: While cmd_hi[p] and cmd_lo[p] are sampled high together, both gates of phase p are off. They turn off two rising edges after the first edge that samples the overlap.
- R3: A command held high while the opposite command is low, with all supplies good and the gate armed, turns its gate on at the (DEAD_CYC+2)-th rising edge after the first edge that samples it (DEAD_CYC = 54 by default).
- R4: A command that goes low turns its gate off at the 2nd rising edge after the first edge that samples it low, whatever the state of the dead-time count.
- R5: On a swap from one side to the other, the newly commanded gate turns on DEAD_CYC+1 edges after the opposite gate turns off.
- R6: vdd_ok low (0 = under-voltage) turns all six gates off two edges after it is sampled.
- R7: boot_ok[p] low turns off gate_hi[p] only. gate_lo[p] and the other phases are unaffected.
- R8: After reset, and after a supply fault that blocked a gate clears, that gate stays off while its command stays high. It turns on only after the command is sampled low and then high again, plus the dead time.
- R9: If a command drops before its dead time has run out, the next assertion restarts the full dead time.
- R10: gate_hi[p] and gate_lo[p] are never both high in the same cycle.
- R11: All three phases have identical turn-on and turn-off latency, so the dead-time mismatch between phases is zero cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_hi | input | 3 | High-side on-command per phase, 1 = on |
| cmd_lo | input | 3 | Low-side on-command per phase, 1 = on |
| vdd_ok | input | 1 | Shared low-side supply good, 0 = under-voltage |
| boot_ok | input | 3 | Per-phase bootstrap supply good, 0 = under-voltage |
| gate_hi | output | 3 | High-side gate enable per phase |
| gate_lo | output | 3 | Low-side gate enable per phase |

## Verification
Two events can land on the same clock edge. One gate's dead-time count can complete on the edge where the opposite command rises, or on the edge where a supply flag falls. The bench provokes both by swapping sides while dropping supply flags at random, both in directed cases and over a long random stream. A cycle-by-cycle reference model, written from the requirements, predicts every gate, and on each edge the bench separately checks that no phase has both gates high.

// File: rtl/gg_pkg.sv
package gg_pkg;

  // Cycles needed to cover a time in ns at a clock period in ps (rounded up).
  function automatic int ns_to_cycles(input int t_ns, input int period_ps);
    return (t_ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  // Counter width able to hold the value lim (at least one bit).
  function automatic int cnt_bits(input int lim);
    int b;
    b = 1;
    while ((1 << b) <= lim) b++;
    return b;
  endfunction

endpackage

// File: rtl/gg_sync.sv
module gg_sync #(
  parameter int W   = 10,
  parameter int STG = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STG];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= d;
  end

  for (genvar i = 1; i < STG; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STG-1];
endmodule

// File: rtl/gg_deadtime.sv
module gg_deadtime #(
  parameter int DEAD = 54
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic gate
);
  localparam int W = gg_pkg::cnt_bits(DEAD);
  localparam logic [W-1:0] LIM = W'(DEAD);

  logic [W-1:0] cnt;
  logic         run_done;

  assign run_done = (cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      gate <= 1'b0;
    end else begin
      gate <= req && run_done;
      if (!req)          cnt <= '0;
      else if (!run_done) cnt <= cnt + 1'b1;
    end
  end

  // R4: a dropped request removes the gate on the next edge
  a_r4_off_fast: assert property (@(posedge clk) disable iff (rst)
    !req |=> !gate);
  // R9: the gate can only rise after the count has been restarted from zero
  a_r9_rise_needs_req: assert property (@(posedge clk) disable iff (rst)
    $rose(gate) |-> $past(req));
endmodule

// File: rtl/gg_phase.sv
module gg_phase #(
  parameter int DEAD = 54
) (
  input  logic clk,
  input  logic rst,
  input  logic hi_s,
  input  logic lo_s,
  input  logic vdd_ok_s,
  input  logic boot_ok_s,
  output logic gate_hi,
  output logic gate_lo
);
  logic hi_ok, lo_ok;
  logic arm_hi, arm_lo;
  logic overlap;
  logic hi_req, lo_req;

  assign hi_ok   = vdd_ok_s && boot_ok_s;
  assign lo_ok   = vdd_ok_s;
  assign overlap = hi_s && lo_s;

  // Arming: cleared while the side's supply is bad, set once the command is seen low.
  always_ff @(posedge clk) begin
    if (rst) begin
      arm_hi <= 1'b0;
      arm_lo <= 1'b0;
    end else begin
      arm_hi <= hi_ok && (arm_hi || !hi_s);
      arm_lo <= lo_ok && (arm_lo || !lo_s);
    end
  end

  assign hi_req = hi_s && !overlap && hi_ok && arm_hi && !gate_lo;
  assign lo_req = lo_s && !overlap && lo_ok && arm_lo && !gate_hi;

  gg_deadtime #(.DEAD(DEAD)) u_hi (
    .clk(clk), .rst(rst), .req(hi_req), .gate(gate_hi)
  );
  gg_deadtime #(.DEAD(DEAD)) u_lo (
    .clk(clk), .rst(rst), .req(lo_req), .gate(gate_lo)
  );

  a_r10_never_both: assert property (@(posedge clk) disable iff (rst)
    !(gate_hi && gate_lo));
  a_r2_overlap_off: assert property (@(posedge clk) disable iff (rst)
    overlap |=> (!gate_hi && !gate_lo));
  a_r6_vdd_off: assert property (@(posedge clk) disable iff (rst)
    !vdd_ok_s |=> (!gate_hi && !gate_lo));
  a_r7_boot_off: assert property (@(posedge clk) disable iff (rst)
    !boot_ok_s |=> !gate_hi);
  a_r8_no_resume: assert property (@(posedge clk) disable iff (rst)
    ($rose(hi_ok) && hi_s) |=> !gate_hi);
endmodule

// File: rtl/inverter_gate_guard.sv
module inverter_gate_guard #(
  parameter int NPH      = 3,
  parameter int CLK_PS   = 5000,
  parameter int DEAD_NS  = 270,
  parameter int SYNC_STG = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] cmd_hi,
  input  logic [NPH-1:0] cmd_lo,
  input  logic           vdd_ok,
  input  logic [NPH-1:0] boot_ok,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo
);
  localparam int DEAD_CYC = gg_pkg::ns_to_cycles(DEAD_NS, CLK_PS);
  localparam int SW       = 3 * NPH + 1;

  logic [SW-1:0]  raw, synced;
  logic [NPH-1:0] hi_s, lo_s, boot_s;
  logic           vdd_s;

  assign raw = {vdd_ok, boot_ok, cmd_lo, cmd_hi};

  gg_sync #(.W(SW), .STG(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  assign hi_s   = synced[NPH-1:0];
  assign lo_s   = synced[2*NPH-1:NPH];
  assign boot_s = synced[3*NPH-1:2*NPH];
  assign vdd_s  = synced[SW-1];

  for (genvar p = 0; p < NPH; p++) begin : g_phase
    gg_phase #(.DEAD(DEAD_CYC)) u_ph (
      .clk(clk), .rst(rst),
      .hi_s(hi_s[p]), .lo_s(lo_s[p]),
      .vdd_ok_s(vdd_s), .boot_ok_s(boot_s[p]),
      .gate_hi(gate_hi[p]), .gate_lo(gate_lo[p])
    );
  end
endmodule

// File: tb/inverter_gate_guard_tb.sv
module inverter_gate_guard_tb;
  localparam int DT = 54;   // 270 ns / 5 ns

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] cmd_hi = '0, cmd_lo = '0, boot_ok = '0;
  logic vdd_ok = 1'b0;
  logic [2:0] gate_hi, gate_lo;

  always #2.5 clk = ~clk;

  inverter_gate_guard u_dut (
    .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .vdd_ok(vdd_ok), .boot_ok(boot_ok), .gate_hi(gate_hi), .gate_lo(gate_lo)
  );

  typedef struct { logic [2:0] eh; logic [2:0] el; string tag; } item_t;
  item_t sb[$];

  int vectors = 0, misses = 0;

  // reference state
  logic [9:0] h1 = '0, h2 = '0;
  bit arm_h[3], arm_l[3], gh[3], gl[3];
  int st_h[3], st_l[3];

  task automatic clear_model();
    h1 = '0; h2 = '0;
    for (int p = 0; p < 3; p++) begin
      arm_h[p] = 0; arm_l[p] = 0; gh[p] = 0; gl[p] = 0; st_h[p] = 0; st_l[p] = 0;
    end
  endtask

  // One clock: drive inputs, predict the gates after the coming edge.
  task automatic step(input logic [2:0] h, input logic [2:0] l, input logic m,
                      input logic [2:0] b, input string tag);
    logic [9:0] sv;
    item_t it;
    bit wh, wl, nh[3], nl[3];
    @(negedge clk);
    cmd_hi = h; cmd_lo = l; vdd_ok = m; boot_ok = b;
    sv = h2; h2 = h1; h1 = {m, b, l, h};
    for (int p = 0; p < 3; p++) begin
      bit ch, cl, sm, sb_ok;
      ch = sv[p]; cl = sv[3+p]; sb_ok = sv[6+p]; sm = sv[9];
      wh = ch && !cl && sm && sb_ok && arm_h[p] && !gl[p];
      wl = cl && !ch && sm && arm_l[p] && !gh[p];
      nh[p] = wh && (st_h[p] >= DT);
      nl[p] = wl && (st_l[p] >= DT);
      st_h[p] = wh ? (st_h[p] < DT + 1 ? st_h[p] + 1 : st_h[p]) : 0;
      st_l[p] = wl ? (st_l[p] < DT + 1 ? st_l[p] + 1 : st_l[p]) : 0;
      arm_h[p] = (sm && sb_ok) ? (arm_h[p] || !ch) : 0;
      arm_l[p] = sm ? (arm_l[p] || !cl) : 0;
    end
    for (int p = 0; p < 3; p++) begin
      gh[p] = nh[p]; gl[p] = nl[p];
      it.eh[p] = nh[p]; it.el[p] = nl[p];
    end
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic hold(input logic [2:0] h, input logic [2:0] l, input logic m,
                      input logic [2:0] b, input int n, input string tag);
    for (int i = 0; i < n; i++) step(h, l, m, b, tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (!rst && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      vectors++;
      if (gate_hi !== it.eh || gate_lo !== it.el) begin
        misses++;
        $display("FAIL %s: gate_hi=%b gate_lo=%b expected %b %b", it.tag,
                 gate_hi, gate_lo, it.eh, it.el);
      end
      vectors++;
      if ((gate_hi & gate_lo) != 3'b000) begin
        misses++;
        $display("FAIL R10: both gates high, hi=%b lo=%b expected overlap 000",
                 gate_hi, gate_lo);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    clear_model();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // reset state (R8)
    #0.5;
    vectors++;
    if (gate_hi !== 3'b000 || gate_lo !== 3'b000) begin
      misses++;
      $display("FAIL R8: reset gates %b %b expected 000 000", gate_hi, gate_lo);
    end
    hold(3'b000, 3'b000, 1, 3'b111, 4, "R8");
    // R3 turn-on with dead time, R4 fast turn-off
    hold(3'b001, 3'b000, 1, 3'b111, DT + 8, "R3");
    hold(3'b000, 3'b000, 1, 3'b111, 6, "R4");
    // R5 swap sides in one cycle
    hold(3'b001, 3'b000, 1, 3'b111, DT + 8, "R5");
    hold(3'b000, 3'b001, 1, 3'b111, DT + 8, "R5");
    hold(3'b001, 3'b000, 1, 3'b111, DT + 8, "R5");
    // R2 overlap
    hold(3'b001, 3'b001, 1, 3'b111, 20, "R2");
    hold(3'b000, 3'b001, 1, 3'b111, DT + 8, "R2");
    hold(3'b000, 3'b000, 1, 3'b111, 4, "R2");
    // R9 short pulse restarts the count
    hold(3'b010, 3'b000, 1, 3'b111, DT / 2, "R9");
    hold(3'b000, 3'b000, 1, 3'b111, 1, "R9");
    hold(3'b010, 3'b000, 1, 3'b111, DT + 8, "R9");
    // R11 all phases together; R1 phase independence
    hold(3'b000, 3'b000, 1, 3'b111, 4, "R11");
    hold(3'b111, 3'b000, 1, 3'b111, DT + 8, "R11");
    hold(3'b101, 3'b010, 1, 3'b111, DT + 8, "R1");
    // R7 one bootstrap flag low
    hold(3'b101, 3'b010, 1, 3'b110, 20, "R7");
    hold(3'b100, 3'b011, 1, 3'b110, DT + 8, "R7");
    // R8 flag returns while command stays high: no resume
    hold(3'b101, 3'b010, 1, 3'b111, DT + 8, "R8");
    hold(3'b100, 3'b010, 1, 3'b111, 3, "R8");
    hold(3'b101, 3'b010, 1, 3'b111, DT + 8, "R8");
    // R6 shared supply low
    hold(3'b101, 3'b010, 0, 3'b111, 20, "R6");
    hold(3'b101, 3'b010, 1, 3'b111, DT + 8, "R6");
    hold(3'b000, 3'b000, 1, 3'b111, 3, "R6");
    hold(3'b101, 3'b010, 1, 3'b111, DT + 8, "R6");
    // random stream: swaps, overlaps, supply flags dropping
    for (int k = 0; k < 400; k++) begin
      logic [2:0] rh, rl, rb;
      logic rm;
      int n;
      rh = 3'($urandom); rl = 3'($urandom) & ~(($urandom % 4 == 0) ? 3'b000 : rh);
      rm = ($urandom % 10) != 0;
      rb = (($urandom % 6) == 0) ? 3'($urandom) : 3'b111;
      n = 1 + ($urandom % (DT + 40));
      hold(rh, rl, rm, rb, n, "R10");
    end
    hold(3'b000, 3'b000, 1, 3'b111, 4, "R4");
    @(negedge clk);
    finish_run();
  end
endmodule